// File: doc/BRIEF.md
# PCI Command and Status Error Register Pair

This block holds the 16-bit command word and the 16-bit status word of a PCI function's configuration header. Both live in one 32-bit configuration dword: the command word occupies bits 15:0 and the status word occupies bits 31:16. A simple register port writes this dword under per-byte enables and reads it back.

The bus logic of the function reports events to the block as single-cycle pulses. These events are a detected parity error, a signalled system error, a received master abort, a received target abort, a signalled target abort, and an observed PERR during a data phase, together with a flag that says the function is bus master. The block records each event in a sticky status flag. Software clears a flag by writing 1 to its position. The command word drives the memory-space and I/O-space claim enables, which the bus logic uses to decide whether to claim a cycle. It also drives the parity-response enable and the system-error enable, which gate two of the status flags.

Address decoding of configuration cycles, parity generation and the bus state machine are outside this block. Every register in it, including the sticky flags, is cleared only by the global reset input.

Top module: `pci_cfg_cmdsts`

## Requirements
- R1: After global reset, a read of the command/status dword returns 0x0210_0000, and io_space_en, mem_space_en, par_resp_en and serr_en are all 0.
- R2: Writable command bits are bit 0 (I/O enable), bit 1 (memory enable), bit 6 (parity-response enable) and bit 8 (system-error enable). A bit is written only when the enable of its byte is set (wr_be[0] for bits 7:0, wr_be[1] for bits 15:8). All other command bits read as 0.
- R3: Status flags are bits 15, 14, 13, 12, 11 and 8 of the status word (dword bits 31..27 and 24). Writing 1 under wr_be[3] clears a flag. Writing 0, or writing without wr_be[3], leaves it unchanged.
- R4: A pulse on ev_par_det sets bit 15, on ev_mabort_rcv sets bit 13, on ev_tabort_rcv sets bit 12, and on ev_tabort_sig sets bit 11. The flag is visible from the next cycle on.
- R5: A pulse on ev_serr_sig sets status bit 14 only while the command system-error enable (bit 8) is 1.
- R6: Status bit 8 sets only when ev_perr_seen and bus_master are both high in the same cycle while the command parity-response enable (bit 6) is 1.
- R7: Status bits 10:9 always read 01b, bit 4 reads 1, and bits 7:5, 3:0 read 0. Writes to these bits have no effect.
- R8: When a set event and a write-one-to-clear reach the same flag in the same cycle, the flag ends up set.
- R9: Only dword offset 0x04 is decoded. Writes elsewhere change nothing, and reads elsewhere return 0.
- R10: rd_data presents the dword one cycle after rd_en, using the register state of the rd_en cycle. While no read is issued, rd_data is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Global synchronous active-high reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | ADDR_W | Write byte address (dword aligned) |
| wr_be | input | 4 | Write byte enables |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Configuration read strobe |
| rd_addr | input | ADDR_W | Read byte address |
| rd_data | output | 32 | Registered read data |
| ev_par_det | input | 1 | Address or data parity error detected |
| ev_serr_sig | input | 1 | System error signalled |
| ev_mabort_rcv | input | 1 | Own cycle ended by master abort |
| ev_tabort_rcv | input | 1 | Own cycle ended by target abort |
| ev_tabort_sig | input | 1 | Function ended a cycle with target abort |
| ev_perr_seen | input | 1 | PERR observed in a data phase |
| bus_master | input | 1 | Function is bus master in this phase |
| io_space_en | output | 1 | May claim I/O cycles |
| mem_space_en | output | 1 | May claim memory cycles |
| par_resp_en | output | 1 | Parity-response enable |
| serr_en | output | 1 | System-error enable |

## Verification
The command word is written with full enables, with single byte enables and with all-ones data. These patterns separate the byte gating from the reserved-bit masking. The status word is hit with each event alone, with the gated events both with and without their enables, and with the data-parity condition missing one term at a time, so a wrong gating term shows up. Clear writes are tried as all-ones, as zeros and without the upper byte enable, and one clear arrives in the same cycle as a set. Reads at a wrong offset, back-to-back reads and a read in the same cycle as an event pin down decoding and read timing.

// File: rtl/pci_cfg_pkg.sv
package pci_cfg_pkg;
  localparam int unsigned HALF_W = 16;
  localparam int unsigned DW_W   = 2 * HALF_W;
  localparam int unsigned BE_W   = DW_W / 8;

  typedef logic [HALF_W-1:0] half_t;

  // command bit positions
  localparam int unsigned CMD_IO    = 0;
  localparam int unsigned CMD_MEM   = 1;
  localparam int unsigned CMD_PRESP = 6;
  localparam int unsigned CMD_SERR  = 8;
  localparam half_t CMD_RW_MASK = half_t'((1 << CMD_IO) | (1 << CMD_MEM) |
                                          (1 << CMD_PRESP) | (1 << CMD_SERR));

  // status bit positions
  localparam int unsigned STS_PAR   = 15;
  localparam int unsigned STS_SERR  = 14;
  localparam int unsigned STS_MABT  = 13;
  localparam int unsigned STS_TABR  = 12;
  localparam int unsigned STS_TABS  = 11;
  localparam int unsigned STS_DPAR  = 8;
  localparam half_t STS_STICKY_MASK = half_t'((1 << STS_PAR) | (1 << STS_SERR) |
                                              (1 << STS_MABT) | (1 << STS_TABR) |
                                              (1 << STS_TABS) | (1 << STS_DPAR));
  // hardwired bits: medium select timing (10:9 = 01b) and bit 4 = 1
  localparam half_t STS_FIXED = 16'h0210;
endpackage

// File: rtl/pci_cfg_wdec.sv
module pci_cfg_wdec
  import pci_cfg_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'h04
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BE_W-1:0]   wr_be,
  output logic [BE_W-1:0]   byte_wr
);
  logic hit;
  // dword decode; byte offset bits ignored
  assign hit     = wr_en && (wr_addr[ADDR_W-1:2] == BASE_ADDR[ADDR_W-1:2]);
  assign byte_wr = wr_be & {BE_W{hit}};
endmodule

// File: rtl/pci_cmd_reg.sv
module pci_cmd_reg
  import pci_cfg_pkg::*;
#(
  parameter half_t RW_MASK = CMD_RW_MASK
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] byte_wr,
  input  half_t      wdata,
  output half_t      cmd_word
);
  for (genvar b = 0; b < HALF_W; b++) begin : g_bit
    if (RW_MASK[b]) begin : g_rw
      logic bit_q;
      always_ff @(posedge clk) begin
        if (rst)                bit_q <= 1'b0;
        else if (byte_wr[b/8])  bit_q <= wdata[b];
      end
      assign cmd_word[b] = bit_q;
    end else begin : g_rsv
      assign cmd_word[b] = 1'b0;
    end
  end
endmodule

// File: rtl/pci_sts_reg.sv
module pci_sts_reg
  import pci_cfg_pkg::*;
#(
  parameter half_t STICKY = STS_STICKY_MASK,
  parameter half_t FIXED  = STS_FIXED
) (
  input  logic       clk,
  input  logic       rst,
  input  half_t      set_vec,
  input  logic [1:0] byte_wr,
  input  half_t      wdata,
  output half_t      sts_word
);
  for (genvar b = 0; b < HALF_W; b++) begin : g_bit
    if (STICKY[b]) begin : g_w1c
      logic flag_q;
      logic clr;
      assign clr = byte_wr[b/8] && wdata[b];
      // a set in the same cycle outranks the clear
      always_ff @(posedge clk) begin
        if (rst) flag_q <= 1'b0;
        else     flag_q <= (flag_q && !clr) || set_vec[b];
      end
      assign sts_word[b] = flag_q;
    end else begin : g_ro
      assign sts_word[b] = FIXED[b];
    end
  end
endmodule

// File: rtl/pci_cfg_rdport.sv
module pci_cfg_rdport
  import pci_cfg_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'h04
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  half_t             cmd_word,
  input  half_t             sts_word,
  output logic [DW_W-1:0]   rd_data
);
  logic hit;
  assign hit = rd_en && (rd_addr[ADDR_W-1:2] == BASE_ADDR[ADDR_W-1:2]);

  always_ff @(posedge clk) begin
    if (rst)      rd_data <= '0;
    else if (hit) rd_data <= {sts_word, cmd_word};
    else          rd_data <= '0;
  end
endmodule

// File: rtl/pci_cfg_cmdsts.sv
module pci_cfg_cmdsts
  import pci_cfg_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'h04
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [3:0]        wr_be,
  input  logic [31:0]       wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  input  logic              ev_par_det,
  input  logic              ev_serr_sig,
  input  logic              ev_mabort_rcv,
  input  logic              ev_tabort_rcv,
  input  logic              ev_tabort_sig,
  input  logic              ev_perr_seen,
  input  logic              bus_master,
  output logic              io_space_en,
  output logic              mem_space_en,
  output logic              par_resp_en,
  output logic              serr_en
);
  logic [BE_W-1:0] byte_wr;
  half_t           cmd_word;
  half_t           sts_word;
  half_t           set_vec;

  pci_cfg_wdec #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_wdec (
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_be   (wr_be),
    .byte_wr (byte_wr)
  );

  pci_cmd_reg u_cmd (
    .clk      (clk),
    .rst      (rst),
    .byte_wr  (byte_wr[1:0]),
    .wdata    (wr_data[HALF_W-1:0]),
    .cmd_word (cmd_word)
  );

  assign io_space_en  = cmd_word[CMD_IO];
  assign mem_space_en = cmd_word[CMD_MEM];
  assign par_resp_en  = cmd_word[CMD_PRESP];
  assign serr_en      = cmd_word[CMD_SERR];

  // event to flag mapping; gates use the registered command bits
  always_comb begin
    set_vec           = '0;
    set_vec[STS_PAR]  = ev_par_det;
    set_vec[STS_SERR] = ev_serr_sig && serr_en;
    set_vec[STS_MABT] = ev_mabort_rcv;
    set_vec[STS_TABR] = ev_tabort_rcv;
    set_vec[STS_TABS] = ev_tabort_sig;
    set_vec[STS_DPAR] = ev_perr_seen && bus_master && par_resp_en;
  end

  pci_sts_reg u_sts (
    .clk      (clk),
    .rst      (rst),
    .set_vec  (set_vec),
    .byte_wr  (byte_wr[3:2]),
    .wdata    (wr_data[DW_W-1:HALF_W]),
    .sts_word (sts_word)
  );

  pci_cfg_rdport #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_rd (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .cmd_word (cmd_word),
    .sts_word (sts_word),
    .rd_data  (rd_data)
  );
endmodule

// File: rtl/pci_cfg_cmdsts_chk.sv
module pci_cfg_cmdsts_chk #(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'h04
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [3:0]        wr_be,
  input logic [31:0]       wr_data,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [31:0]       rd_data,
  input logic              ev_par_det,
  input logic              ev_mabort_rcv,
  input logic              ev_tabort_sig,
  input logic              ev_perr_seen,
  input logic              bus_master,
  input logic              serr_en,
  input logic [15:0]       sts_word
);
  logic wr_hi, rd_hit;
  assign wr_hi  = wr_en && wr_be[3] && (wr_addr[ADDR_W-1:2] == BASE_ADDR[ADDR_W-1:2]);
  assign rd_hit = rd_en && (rd_addr[ADDR_W-1:2] == BASE_ADDR[ADDR_W-1:2]);

  a_r4_par_sets: assert property (@(posedge clk) disable iff (rst)
    ev_par_det |=> sts_word[15]);
  a_r4_tabort_sig_sets: assert property (@(posedge clk) disable iff (rst)
    ev_tabort_sig |=> sts_word[11]);
  a_r8_set_beats_clear: assert property (@(posedge clk) disable iff (rst)
    (ev_mabort_rcv && wr_hi && wr_data[29]) |=> sts_word[13]);
  a_r3_clear: assert property (@(posedge clk) disable iff (rst)
    (wr_hi && wr_data[29] && !ev_mabort_rcv) |=> !sts_word[13]);
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    (!ev_par_det && !(wr_hi && wr_data[31])) |=> $stable(sts_word[15]));
  a_r5_serr_gate: assert property (@(posedge clk) disable iff (rst)
    (!serr_en && !sts_word[14]) |=> !sts_word[14]);
  a_r6_perr_gate: assert property (@(posedge clk) disable iff (rst)
    (!(ev_perr_seen && bus_master) && !sts_word[8]) |=> !sts_word[8]);
  a_r7_fixed_bits: assert property (@(posedge clk) disable iff (rst)
    rd_hit |=> (rd_data[26:25] == 2'b01) && (rd_data[23:16] == 8'h10));
  a_r10_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (rd_data == 32'h0));
endmodule

bind pci_cfg_cmdsts pci_cfg_cmdsts_chk #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .wr_en         (wr_en),
  .wr_addr       (wr_addr),
  .wr_be         (wr_be),
  .wr_data       (wr_data),
  .rd_en         (rd_en),
  .rd_addr       (rd_addr),
  .rd_data       (rd_data),
  .ev_par_det    (ev_par_det),
  .ev_mabort_rcv (ev_mabort_rcv),
  .ev_tabort_sig (ev_tabort_sig),
  .ev_perr_seen  (ev_perr_seen),
  .bus_master    (bus_master),
  .serr_en       (serr_en),
  .sts_word      (sts_word)
);

// File: tb/tb_pci_cfg_cmdsts.sv
`timescale 1ns/1ps
module tb_pci_cfg_cmdsts;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = 8'h0;
  logic [3:0]  wr_be = 4'h0;
  logic [31:0] wr_data = 32'h0;
  logic        rd_en = 1'b0;
  logic [7:0]  rd_addr = 8'h0;
  logic [31:0] rd_data;
  logic ev_par_det = 0, ev_serr_sig = 0, ev_mabort_rcv = 0, ev_tabort_rcv = 0;
  logic ev_tabort_sig = 0, ev_perr_seen = 0, bus_master = 0;
  logic io_space_en, mem_space_en, par_resp_en, serr_en;

  int unsigned n_checks = 0;
  int unsigned n_errs   = 0;
  int unsigned cyc      = 0;
  bit          done     = 0;
  logic        rd_pend  = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  pci_cfg_cmdsts dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_be(wr_be),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .ev_par_det(ev_par_det), .ev_serr_sig(ev_serr_sig), .ev_mabort_rcv(ev_mabort_rcv),
    .ev_tabort_rcv(ev_tabort_rcv), .ev_tabort_sig(ev_tabort_sig),
    .ev_perr_seen(ev_perr_seen), .bus_master(bus_master),
    .io_space_en(io_space_en), .mem_space_en(mem_space_en),
    .par_resp_en(par_resp_en), .serr_en(serr_en)
  );

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  endtask

  // monitor: a read issued in cycle t is compared at the falling edge after t+1
  always @(posedge clk) rd_pend <= rd_en;
  always @(negedge clk) begin
    if (rd_pend && !rst) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_checks++;
      if (rd_data !== e) begin
        n_errs++;
        $display("FAIL %s: rd_data=%h expected=%h", t, rd_data, e);
      end
    end else if (!rst) begin
      n_checks++;
      if (rd_data !== 32'h0) begin
        n_errs++;
        $display("FAIL R10 idle: rd_data=%h expected=00000000", rd_data);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      n_errs++; n_checks++;
      $display("FAIL watchdog: cycles=%0d expected=<20000", cyc);
      summary();
    end
  end

  task automatic chk(input string t, input logic [3:0] act, input logic [3:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s: act=%h expected=%h", t, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
    wr_en = 1; wr_addr = a; wr_be = be; wr_data = d;
    @(negedge clk);
    wr_en = 0; wr_be = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    rd_en = 1; rd_addr = a;
    @(negedge clk);
    rd_en = 0;
  endtask

  // one-cycle event pulse: {par, serr, mabt, tabr, tabs, perr, master}
  task automatic ev(input logic [6:0] v);
    {ev_par_det, ev_serr_sig, ev_mabort_rcv, ev_tabort_rcv, ev_tabort_sig,
     ev_perr_seen, bus_master} = v;
    @(negedge clk);
    {ev_par_det, ev_serr_sig, ev_mabort_rcv, ev_tabort_rcv, ev_tabort_sig,
     ev_perr_seen, bus_master} = '0;
  endtask

  task automatic drain();
    @(negedge clk); @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    rd(8'h04, 32'h0210_0000, "R1 reset value");
    chk("R1 enables after reset", {io_space_en, mem_space_en, par_resp_en, serr_en}, 4'h0);

    wr(8'h04, 4'b0001, 32'h0000_0043);
    chk("R2 io/mem/presp set", {io_space_en, mem_space_en, par_resp_en, serr_en}, 4'b1110);
    wr(8'h04, 4'b0011, 32'h0000_FFFF);
    rd(8'h04, 32'h0210_0143, "R2 reserved command bits zero");
    wr(8'h04, 4'b0010, 32'h0000_0000);
    rd(8'h04, 32'h0210_0043, "R2 byte1 only clears serr enable");

    ev(7'b1000000); ev(7'b0010000); ev(7'b0001000); ev(7'b0000100);
    ev(7'b0100000);
    rd(8'h04, 32'hBA10_0043, "R4/R5 events set, serr gated off");

    wr(8'h04, 4'b0011, 32'h0000_0143);
    ev(7'b0100000);
    rd(8'h04, 32'hFA10_0143, "R5 serr sets when enabled");

    wr(8'h04, 4'b0011, 32'h0000_0103);
    ev(7'b0000011);
    rd(8'h04, 32'hFA10_0103, "R6 no set with parity response off");
    wr(8'h04, 4'b0011, 32'h0000_0143);
    ev(7'b0000010);
    ev(7'b0000001);
    rd(8'h04, 32'hFA10_0143, "R6 no set without master or perr");
    ev(7'b0000011);
    rd(8'h04, 32'hFB10_0143, "R6 data parity flag sets");

    wr(8'h04, 4'b0100, 32'hFFFF_FFFF);
    rd(8'h04, 32'hFB10_0143, "R3/R7 no clear without upper byte enable");
    wr(8'h04, 4'b1000, 32'h2000_0000);
    rd(8'h04, 32'hDB10_0143, "R3 clear master abort flag");
    wr(8'h04, 4'b1000, 32'h0000_0000);
    rd(8'h04, 32'hDB10_0143, "R3 zero write no effect");
    wr(8'h04, 4'b1100, 32'hFFFF_0143);
    rd(8'h04, 32'h0210_0143, "R3/R7 clear all, fixed bits kept");

    // R8: clear and set of target-abort-received in the same cycle
    ev_tabort_rcv = 1;
    wr(8'h04, 4'b1000, 32'h1000_0000);
    ev_tabort_rcv = 0;
    rd(8'h04, 32'h1210_0143, "R8 set wins over clear");

    wr(8'h08, 4'b1111, 32'hFFFF_FFFF);
    rd(8'h08, 32'h0000_0000, "R9 other offset reads zero");
    rd(8'h04, 32'h1210_0143, "R9 other offset write ignored");
    chk("R9 enables unchanged", {io_space_en, mem_space_en, par_resp_en, serr_en}, 4'hF);

    wr(8'h04, 4'b1000, 32'hFF00_0000);
    ev_par_det = 1;
    rd(8'h04, 32'h0210_0143, "R10 read sees state of its own cycle");
    ev_par_det = 0;
    rd(8'h04, 32'h8210_0143, "R10 back-to-back read sees event");
    drain();

    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    @(negedge clk);
    rd(8'h04, 32'h0210_0000, "R1 second reset clears flags");
    chk("R1 enables after second reset", {io_space_en, mem_space_en, par_resp_en, serr_en}, 4'h0);
    drain();
    done = 1;
    summary();
  end
endmodule